// File: doc/BRIEF.md
# BCD Calendar Alarm Comparator

This block holds a wake-up alarm as six BCD bytes: seconds, minutes, hours, day of month, month and two-digit year, where year 00 to 99 stands for 2000 to 2099 and month runs 1 to 12. The block sits next to a calendar timekeeper, which presents its live time on `cal_now` and pulses `cal_tick` for one clock whenever that time advances. There is no weekday field. Only the six date and time bytes take part in the comparison.

When a tick arrives and all six live fields equal the stored alarm, the block raises a sticky status flag. Software clears the flag by writing a 1 to it. The interrupt output is the flag qualified by a single enable bit. Software can therefore turn the enable bit off, rewrite the alarm fields freely and turn it back on, and no interrupt appears while it does so. Setting the enable bit while an event is already pending raises the interrupt straight away.

Software reaches the block through a small synchronous register port. A write takes effect at the clock edge where `reg_we` is high. Read data is registered, so it shows the register at `reg_addr` one edge later.

Top module: `cal_alarm_match`

## Requirements
- R1: After synchronous reset, all six alarm fields, the enable bit, the status flag, `reg_rdata` and `alarm_irq` are 0.
- R2: Register addresses 0 to 5 hold seconds, minutes, hours, day, month and year. A write stores the data ANDed with 8'h7F, 8'h7F, 8'h3F, 8'h3F, 8'h1F and 8'hFF respectively, and a read of the same address returns the stored value on `reg_rdata` one edge after the address is presented.
- R3: On a cycle with `cal_tick` high where every byte of `cal_now` equals its alarm field, the status flag reads 1 starting two edges later. Byte i of `cal_now` is bits [8i+7:8i], in the same field order as R2.
- R4: An event is taken only on a tick where equality begins. A tick whose previous tick was already equal raises no new event, and equality without a tick raises none.
- R5: A difference in any single one of the six fields prevents the event.
- R6: The status flag sits at bit 0 of address 7. It stays 1 until a write to address 7 with bit 0 = 1 clears it, and a write with bit 0 = 0 leaves it unchanged.
- R7: If a clearing write lands on the same edge at which a new event sets the flag, the flag ends up 1.
- R8: The enable bit sits at bit 0 of address 6. `alarm_irq` goes high one edge after both flag and enable are 1, and stays 0 while enable is 0. Matches and alarm rewrites made while enable is 0 cause no interrupt.
- R9: Setting the enable bit while the flag is already 1 drives `alarm_irq` high on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_tick | input | 1 | One-cycle pulse when the live calendar advances |
| cal_now | input | 48 | Live calendar, six BCD bytes, seconds in the low byte, year in the high byte |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr` |
| alarm_irq | output | 1 | Registered interrupt: status flag AND enable |

## Verification
The bench walks each alarm field through patterns with all bits set and with alternating bits. A design that dropped or misplaced a width mask would read back stray high bits. It then upsets one field at a time by a single BCD unit. A comparator that skipped a field, or that compared the wrong byte lane, would raise a false event. The bench repeats ticks on an unchanged matching calendar and holds equality with no tick. A level-sensitive comparator would refire the flag after each clear. Finally, the bench aims a clear at the exact edge where a new event lands and toggles the enable bit around a pending flag. A design that let the clear win would lose an alarm. A design with ungated or unregistered interrupt logic would show the interrupt during disabled rewrites, or fail to show it as soon as the enable bit is set.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

  localparam int unsigned FIELD_COUNT = 6;
  localparam int unsigned FIELD_W     = 8;
  localparam int unsigned REG_AW      = 3;

  // Significant BCD bits per field; upper bits can never be non-zero in a
  // valid calendar value and are dropped when software writes the field.
  function automatic logic [63:0] field_mask(int unsigned idx);
    case (idx)
      0, 1:    field_mask = 64'h7F;  // seconds, minutes: 0..59
      2, 3:    field_mask = 64'h3F;  // hours 0..23, day 1..31
      4:       field_mask = 64'h1F;  // month 1..12
      default: field_mask = 64'hFF;  // year 00..99
    endcase
  endfunction

endpackage

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int unsigned FIELDS = FIELD_COUNT,
  parameter int unsigned DW     = FIELD_W,
  parameter int unsigned AW     = REG_AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  output logic [FIELDS*DW-1:0] alarm_flat,
  output logic                 irq_en
);

  localparam logic [AW-1:0] CTRL_ADDR = AW'(FIELDS);

  for (genvar g = 0; g < FIELDS; g++) begin : g_field
    localparam logic [DW-1:0] MASK = DW'(field_mask(g));
    logic [DW-1:0] val_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= '0;
      end else if (wr_en && wr_addr == AW'(g)) begin
        val_q <= wr_data & MASK;
      end
    end

    assign alarm_flat[g*DW +: DW] = val_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en <= 1'b0;
    end else if (wr_en && wr_addr == CTRL_ADDR) begin
      irq_en <= wr_data[0];
    end
  end

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
#(
  parameter int unsigned FIELDS = FIELD_COUNT,
  parameter int unsigned DW     = FIELD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [FIELDS*DW-1:0] alarm_flat,
  input  logic [FIELDS*DW-1:0] cal_flat,
  output logic                 hit
);

  logic [FIELDS-1:0] lane_eq;
  logic              all_eq;
  logic              prev_eq_q;

  for (genvar g = 0; g < FIELDS; g++) begin : g_lane
    assign lane_eq[g] = (alarm_flat[g*DW +: DW] == cal_flat[g*DW +: DW]);
  end

  assign all_eq = &lane_eq;

  // Equality is sampled only at calendar ticks; an event needs the
  // previous tick to have been unequal, so a frozen calendar fires once.
  always_ff @(posedge clk) begin
    if (rst) begin
      hit       <= 1'b0;
      prev_eq_q <= 1'b0;
    end else begin
      hit <= tick & all_eq & ~prev_eq_q;
      if (tick) begin
        prev_eq_q <= all_eq;
      end
    end
  end

endmodule

// File: rtl/cal_alarm_flag.sv
module cal_alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);

  // A new event outranks a clear landing on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      flag <= hit | (flag & ~clr);
      irq  <= flag & irq_en;
    end
  end

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int unsigned FIELDS = FIELD_COUNT,
  parameter int unsigned DW     = FIELD_W,
  parameter int unsigned AW     = REG_AW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cal_tick,
  input  logic [FIELDS*DW-1:0] cal_now,
  input  logic [AW-1:0]        reg_addr,
  input  logic                 reg_we,
  input  logic [DW-1:0]        reg_wdata,
  output logic [DW-1:0]        reg_rdata,
  output logic                 alarm_irq
);

  localparam logic [AW-1:0] CTRL_ADDR = AW'(FIELDS);
  localparam logic [AW-1:0] STAT_ADDR = AW'(FIELDS + 1);

  logic [FIELDS*DW-1:0] alarm_flat;
  logic                 irq_en;
  logic                 cmp_hit;
  logic                 flag_q;
  logic                 stat_clr;
  logic [DW-1:0]        rd_next;

  cal_alarm_regs #(.FIELDS(FIELDS), .DW(DW), .AW(AW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (reg_we),
    .wr_addr    (reg_addr),
    .wr_data    (reg_wdata),
    .alarm_flat (alarm_flat),
    .irq_en     (irq_en)
  );

  cal_alarm_cmp #(.FIELDS(FIELDS), .DW(DW)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .tick       (cal_tick),
    .alarm_flat (alarm_flat),
    .cal_flat   (cal_now),
    .hit        (cmp_hit)
  );

  assign stat_clr = reg_we && (reg_addr == STAT_ADDR) && reg_wdata[0];

  cal_alarm_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .hit    (cmp_hit),
    .clr    (stat_clr),
    .irq_en (irq_en),
    .flag   (flag_q),
    .irq    (alarm_irq)
  );

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < int'(FIELDS); i++) begin
      if (reg_addr == AW'(i)) begin
        rd_next = alarm_flat[i*DW +: DW];
      end
    end
    if (reg_addr == CTRL_ADDR) begin
      rd_next = {{(DW-1){1'b0}}, irq_en};
    end
    if (reg_addr == STAT_ADDR) begin
      rd_next = {{(DW-1){1'b0}}, flag_q};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= rd_next;
    end
  end

endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk (
  input logic clk,
  input logic rst,
  input logic hit,
  input logic clr,
  input logic flag,
  input logic en,
  input logic irq
);

  p_flag_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(hit));

  p_single_hit_r4: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit);

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);

  p_irq_needs_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag));

  p_irq_on_enable_r9: assert property (@(posedge clk) disable iff (rst)
    (flag && en && !clr) |=> irq);

endmodule

bind cal_alarm_match cal_alarm_chk u_chk (
  .clk  (clk),
  .rst  (rst),
  .hit  (cmp_hit),
  .clr  (stat_clr),
  .flag (flag_q),
  .en   (irq_en),
  .irq  (alarm_irq)
);

// File: tb/test_cal_alarm_match.sv
module test_cal_alarm_match;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cal_tick = 1'b0;
  logic [47:0] cal_now = '0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        alarm_irq;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  cal_alarm_match i_cal_alarm_match (
    .clk       (clk),
    .rst       (rst),
    .cal_tick  (cal_tick),
    .cal_now   (cal_now),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .alarm_irq (alarm_irq)
  );

  // Base alarm: 12:34:56 on day 15, month 07, year 24 (BCD).
  localparam logic [47:0] BASE = {8'h24, 8'h07, 8'h15, 8'h12, 8'h34, 8'h56};

  function automatic logic [7:0] bench_mask(int idx);
    if (idx < 2) return 8'h7F;
    if (idx < 4) return 8'h3F;
    if (idx == 4) return 8'h1F;
    return 8'hFF;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic tick(logic [47:0] t);
    cal_now  = t;
    cal_tick = 1'b1;
    @(negedge clk);
    cal_tick = 1'b0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic load_alarm(logic [47:0] t);
    for (int i = 0; i < 6; i++) wr(3'(i), t[i*8 +: 8]);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", cycles, 100000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] pats [4];
    pats[0] = 8'hFF; pats[1] = 8'hA5; pats[2] = 8'h5A; pats[3] = 8'h00;

    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 irq", {7'b0, alarm_irq}, 8'h00);
    chk("R1 rdata", reg_rdata, 8'h00);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R1 reg", d, 8'h00);
    end

    // R2: per-field write masking and readback
    for (int i = 0; i < 6; i++) begin
      for (int p = 0; p < 4; p++) begin
        wr(3'(i), pats[p]);
        rd(3'(i), d);
        chk("R2 field", d, pats[p] & bench_mask(i));
      end
    end

    load_alarm(BASE);

    // R5: one field off by one BCD unit, enable off
    for (int i = 0; i < 6; i++) begin
      logic [47:0] t;
      t = BASE;
      t[i*8 +: 8] = t[i*8 +: 8] ^ 8'h01;
      tick(t);
      idle(2);
      rd(3'd7, d);
      chk("R5 no event", d, 8'h00);
    end

    // R3: full match sets flag; R8: enable off keeps irq low
    tick(BASE);
    @(negedge clk);
    rd(3'd7, d);
    chk("R3 flag", d, 8'h01);
    chk("R8 masked irq", {7'b0, alarm_irq}, 8'h00);

    // R9: enabling with pending flag raises irq on the next edge
    wr(3'd6, 8'h01);
    @(negedge clk);
    chk("R9 irq", {7'b0, alarm_irq}, 8'h01);

    // R6: write 0 keeps flag, write 1 clears
    wr(3'd7, 8'h00);
    rd(3'd7, d);
    chk("R6 keep", d, 8'h01);
    wr(3'd7, 8'h01);
    @(negedge clk);
    chk("R6 irq cleared", {7'b0, alarm_irq}, 8'h00);
    rd(3'd7, d);
    chk("R6 cleared", d, 8'h00);

    // R4: repeated tick on equal calendar, and equality without tick
    tick(BASE);
    idle(4);
    rd(3'd7, d);
    chk("R4 repeat tick", d, 8'h00);
    chk("R4 repeat irq", {7'b0, alarm_irq}, 8'h00);
    tick(BASE ^ 48'h1);
    cal_now = BASE;
    idle(5);
    rd(3'd7, d);
    chk("R4 no tick", d, 8'h00);
    tick(BASE);
    idle(2);
    chk("R8 irq on match", {7'b0, alarm_irq}, 8'h01);

    // R7: event and clear on the same edge -> flag stays set
    tick(BASE ^ 48'h1);
    cal_now  = BASE;
    cal_tick = 1'b1;
    @(negedge clk);
    cal_tick = 1'b0;
    wr(3'd7, 8'h01);
    rd(3'd7, d);
    chk("R7 set wins", d, 8'h01);

    // R8: disable, clear, rewrite alarm to the presented time: no irq
    wr(3'd6, 8'h00);
    wr(3'd7, 8'h01);
    @(negedge clk);
    chk("R8 disabled", {7'b0, alarm_irq}, 8'h00);
    for (int i = 0; i < 6; i++) begin
      wr(3'(i), 8'h11);
      chk("R8 rewrite", {7'b0, alarm_irq}, 8'h00);
    end
    cal_now = {6{8'h11}};
    idle(3);
    wr(3'd6, 8'h01);
    idle(2);
    chk("R8 enable no flag", {7'b0, alarm_irq}, 8'h00);
    rd(3'd0, d);
    chk("R8 field kept", d, 8'h11);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule